// File: doc/BRIEF.md
# Upward-Growing Word Stack Unit

This block turns push and pop commands into single 16-bit memory transfers on a stack that grows toward higher addresses. It holds the stack segment and stack offset registers. A push writes one full word at the current segment:offset and then advances the offset by two. A pop first steps the offset back by two and then reads the word found there. A value pushed as a byte is widened with a zero upper byte, so every stack slot is one aligned word.

The instruction decoder drives a command (push or pop, byte or word, data) with a valid/ready pair. It can also load new segment and offset values, for example to relocate the stack. The memory side sees one registered request per command. It is a word-wide synchronous memory that returns read data on the cycle after the request. In a word, the low byte belongs at the even address and the high byte at the following odd address.

Top module: `stk_unit`

## Requirements
- R1: After reset the segment output is 2, the offset output is 0, `cmd_ready` is high, and `mem_req` and `pop_valid` are low.
- R2: On the cycle after a push is accepted, `mem_req` is high with `mem_we` = 1 and `mem_addr` = {segment, offset before the push}. In that same cycle the offset output already shows the old offset plus 2.
- R3: For a push with `cmd_wide` = 1, `mem_wdata` equals `cmd_data`. For a push with `cmd_wide` = 0, `mem_wdata` holds `cmd_data[7:0]` in bits 7:0 and zeros in bits 15:8.
- R4: On the cycle after a pop is accepted, `mem_req` is high with `mem_we` = 0 and `mem_addr` = {segment, old offset minus 2}. In that same cycle the offset output already shows the old offset minus 2.
- R5: On the cycle after a pop's read request, `pop_valid` is high for exactly one cycle and `pop_data` equals `mem_rdata`, with the even-address byte in bits 7:0. At all other times `pop_valid` is low.
- R6: A push keeps `cmd_ready` low for one cycle and a pop keeps it low for two cycles. A command presented while `cmd_ready` is low has no effect on the memory request or on the offset.
- R7: Each accepted command raises `mem_req` for exactly one cycle.
- R8: The offset wraps modulo 256 in both directions. Push and pop never change the segment.
- R9: `ld_en` replaces the segment and offset with `ld_ss` and `ld_sp`, visible on the next cycle. When a load and an accepted command fall in the same cycle, the command works on the loaded values.
- R10: An odd offset is not refused. The request is issued at the odd address and the offset still moves by 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_pop | input | 1 | 1 = pop, 0 = push |
| cmd_wide | input | 1 | 1 = 16-bit push value, 0 = 8-bit |
| cmd_data | input | 16 | Value to push |
| cmd_ready | output | 1 | Unit can accept a command |
| ld_en | input | 1 | Load segment and offset |
| ld_ss | input | 8 | Segment value to load |
| ld_sp | input | 8 | Offset value to load |
| ss_o | output | 8 | Current stack segment |
| sp_o | output | 8 | Current stack offset |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write word, 0 = read word |
| mem_addr | output | 16 | Byte address {segment, offset} of the word |
| mem_wdata | output | 16 | Word to write |
| mem_rdata | input | 16 | Word read, one cycle after the request |
| pop_valid | output | 1 | Popped word is on `pop_data` |
| pop_data | output | 16 | Popped word |

## Verification
A register load from the decoder and an accepted push or pop can happen in the same cycle. The bench provokes this by raising `ld_en` in the cycle where the push is accepted. It passes only if the request address and the resulting offset are derived from the loaded values, not the stale ones. The second collision is a new command held on the inputs while an earlier one is still in flight. That case is judged by checking that no extra request appears and that the offset moves only once per accepted command.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_RESP  = 2'd2
  } stk_state_e;

  typedef enum logic {
    OP_PUSH = 1'b0,
    OP_POP  = 1'b1
  } stk_op_e;

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int SEG_W  = 8,
  parameter int OFF_W  = 8,
  parameter int RST_SS = 2,
  parameter int RST_SP = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [SEG_W-1:0] ld_ss,
  input  logic [OFF_W-1:0] ld_sp,
  input  logic             upd_en,
  input  logic             upd_pop,
  output logic [SEG_W-1:0] ss_q,
  output logic [OFF_W-1:0] sp_q,
  output logic [SEG_W-1:0] eff_ss,
  output logic [OFF_W-1:0] eff_sp,
  output logic [OFF_W-1:0] nxt_sp
);

  localparam logic [OFF_W-1:0] STEP = OFF_W'(2);

  function automatic logic [OFF_W-1:0] sp_advance(input logic [OFF_W-1:0] sp);
    return sp + STEP;
  endfunction

  function automatic logic [OFF_W-1:0] sp_retreat(input logic [OFF_W-1:0] sp);
    return sp - STEP;
  endfunction

  // a load in the same cycle as a command is forwarded to the command
  always_comb begin
    eff_ss = ld_en ? ld_ss : ss_q;
    eff_sp = ld_en ? ld_sp : sp_q;
    nxt_sp = upd_pop ? sp_retreat(eff_sp) : sp_advance(eff_sp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q <= SEG_W'(RST_SS);
      sp_q <= OFF_W'(RST_SP);
    end else begin
      if (ld_en) ss_q <= ld_ss;
      if (upd_en)     sp_q <= nxt_sp;
      else if (ld_en) sp_q <= ld_sp;
    end
  end

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_pop,
  output logic cmd_ready,
  output logic accept,
  output logic resp_phase
);

  stk_state_e state_q, state_d;
  stk_op_e    op_q;

  always_comb begin
    cmd_ready  = (state_q == ST_IDLE);
    accept     = cmd_ready && cmd_valid;
    resp_phase = (state_q == ST_RESP);
    state_d    = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_ISSUE;
      ST_ISSUE: state_d = (op_q == OP_POP) ? ST_RESP : ST_IDLE;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_PUSH;
    end else begin
      state_q <= state_d;
      if (accept) op_q <= cmd_pop ? OP_POP : OP_PUSH;
    end
  end

endmodule

// File: rtl/stk_req.sv
module stk_req #(
  parameter int SEG_W  = 8,
  parameter int OFF_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept,
  input  logic                   op_pop,
  input  logic                   wide,
  input  logic [2*BYTE_W-1:0]    data,
  input  logic [SEG_W-1:0]       seg,
  input  logic [OFF_W-1:0]       cur_off,
  input  logic [OFF_W-1:0]       nxt_off,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [SEG_W+OFF_W-1:0] mem_addr,
  output logic [2*BYTE_W-1:0]    mem_wdata
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam int ADDR_W = SEG_W + OFF_W;

  function automatic logic [WORD_W-1:0] pad_word(input logic w, input logic [WORD_W-1:0] d);
    return w ? d : {{BYTE_W{1'b0}}, d[BYTE_W-1:0]};
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [SEG_W-1:0] s,
                                                  input logic [OFF_W-1:0] o);
    return {s, o};
  endfunction

  // push addresses the slot before advancing; pop addresses it after retreating
  logic [OFF_W-1:0] slot_off;
  assign slot_off = op_pop ? nxt_off : cur_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_req <= accept;
      if (accept) begin
        mem_we    <= !op_pop;
        mem_addr  <= join_addr(seg, slot_off);
        mem_wdata <= op_pop ? '0 : pad_word(wide, data);
      end
    end
  end

endmodule

// File: rtl/stk_unit.sv
module stk_unit #(
  parameter int SEG_W  = 8,
  parameter int OFF_W  = 8,
  parameter int BYTE_W = 8,
  parameter int RST_SS = 2,
  parameter int RST_SP = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic                   cmd_pop,
  input  logic                   cmd_wide,
  input  logic [2*BYTE_W-1:0]    cmd_data,
  output logic                   cmd_ready,
  input  logic                   ld_en,
  input  logic [SEG_W-1:0]       ld_ss,
  input  logic [OFF_W-1:0]       ld_sp,
  output logic [SEG_W-1:0]       ss_o,
  output logic [OFF_W-1:0]       sp_o,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [SEG_W+OFF_W-1:0] mem_addr,
  output logic [2*BYTE_W-1:0]    mem_wdata,
  input  logic [2*BYTE_W-1:0]    mem_rdata,
  output logic                   pop_valid,
  output logic [2*BYTE_W-1:0]    pop_data
);

  localparam int WORD_W = 2 * BYTE_W;

  // named internal events, visible to the bound checker
  logic             cmd_accept;
  logic             resp_phase;
  logic [SEG_W-1:0] eff_ss;
  logic [OFF_W-1:0] eff_sp;
  logic [OFF_W-1:0] nxt_sp;

  stk_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_pop    (cmd_pop),
    .cmd_ready  (cmd_ready),
    .accept     (cmd_accept),
    .resp_phase (resp_phase)
  );

  stk_ptr #(
    .SEG_W  (SEG_W),
    .OFF_W  (OFF_W),
    .RST_SS (RST_SS),
    .RST_SP (RST_SP)
  ) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_ss   (ld_ss),
    .ld_sp   (ld_sp),
    .upd_en  (cmd_accept),
    .upd_pop (cmd_pop),
    .ss_q    (ss_o),
    .sp_q    (sp_o),
    .eff_ss  (eff_ss),
    .eff_sp  (eff_sp),
    .nxt_sp  (nxt_sp)
  );

  stk_req #(
    .SEG_W  (SEG_W),
    .OFF_W  (OFF_W),
    .BYTE_W (BYTE_W)
  ) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (cmd_accept),
    .op_pop    (cmd_pop),
    .wide      (cmd_wide),
    .data      (cmd_data),
    .seg       (eff_ss),
    .cur_off   (eff_sp),
    .nxt_off   (nxt_sp),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  assign pop_valid = resp_phase;
  assign pop_data  = resp_phase ? mem_rdata : {WORD_W{1'b0}};

endmodule

// File: rtl/stk_unit_chk.sv
module stk_unit_chk #(
  parameter int SEG_W  = 8,
  parameter int OFF_W  = 8,
  parameter int BYTE_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   accept,
  input logic                   cmd_pop,
  input logic                   cmd_wide,
  input logic                   cmd_ready,
  input logic                   ld_en,
  input logic [SEG_W-1:0]       ld_ss,
  input logic [OFF_W-1:0]       ld_sp,
  input logic [SEG_W-1:0]       ss_o,
  input logic [OFF_W-1:0]       sp_o,
  input logic                   mem_req,
  input logic                   mem_we,
  input logic [2*BYTE_W-1:0]    mem_wdata,
  input logic                   pop_valid
);

  AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_pop && !ld_en) |=> (sp_o == OFF_W'($past(sp_o) + OFF_W'(2)))); // R2
  AST_BYTE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_pop && !cmd_wide) |=> (mem_wdata[2*BYTE_W-1:BYTE_W] == '0)); // R3
  AST_POP_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_pop && !ld_en) |=> (sp_o == OFF_W'($past(sp_o) - OFF_W'(2)))); // R4
  AST_POP_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> pop_valid); // R5
  AST_POP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |=> !pop_valid); // R5
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || pop_valid) |-> !cmd_ready); // R6
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R7
  AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> mem_req); // R7
  AST_SEG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ld_en) |=> $stable(ss_o)); // R8
  AST_SEG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (ss_o == $past(ld_ss))); // R9
  AST_OFF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !accept) |=> (sp_o == $past(ld_sp))); // R9

endmodule

bind stk_unit stk_unit_chk #(
  .SEG_W  (SEG_W),
  .OFF_W  (OFF_W),
  .BYTE_W (BYTE_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (cmd_accept),
  .cmd_pop   (cmd_pop),
  .cmd_wide  (cmd_wide),
  .cmd_ready (cmd_ready),
  .ld_en     (ld_en),
  .ld_ss     (ld_ss),
  .ld_sp     (ld_sp),
  .ss_o      (ss_o),
  .sp_o      (sp_o),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .pop_valid (pop_valid)
);

// File: tb/stk_unit_tb_top.sv
module stk_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_pop = 1'b0;
  logic        cmd_wide = 1'b0;
  logic [15:0] cmd_data = '0;
  logic        cmd_ready;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_ss = '0;
  logic [7:0]  ld_sp = '0;
  logic [7:0]  ss_o;
  logic [7:0]  sp_o;
  logic        mem_req;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        pop_valid;
  logic [15:0] pop_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stk_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_pop(cmd_pop),
    .cmd_wide(cmd_wide), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
    .ld_en(ld_en), .ld_ss(ld_ss), .ld_sp(ld_sp), .ss_o(ss_o), .sp_o(sp_o),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pop_valid(pop_valid),
    .pop_data(pop_data)
  );

  // byte-addressed memory model: low byte at the even address
  logic [7:0] mem [int];

  function automatic logic [7:0] rd_byte(input int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[int'(mem_addr)]                 = mem_wdata[7:0];
        mem[int'(16'(mem_addr + 16'd1))]    = mem_wdata[15:8];
      end else begin
        mem_rdata <= {rd_byte(int'(16'(mem_addr + 16'd1))), rd_byte(int'(mem_addr))};
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] s, input logic [7:0] p);
    ld_en = 1'b1; ld_ss = s; ld_sp = p;
    @(negedge clk);
    ld_en = 1'b0;
    check("R9", "loaded segment", 32'(ss_o), 32'(s));
    check("R9", "loaded offset", 32'(sp_o), 32'(p));
  endtask

  // entered at a negedge with the unit idle
  task automatic run_cmd(input logic pop, input logic wide, input logic [15:0] data,
                         input logic [15:0] exp_addr, input logic [7:0] exp_sp,
                         input logic [15:0] exp_word);
    cmd_valid = 1'b1; cmd_pop = pop; cmd_wide = wide; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0; ld_en = 1'b0;
    check("R7", "request raised", 32'(mem_req), 32'd1);
    check(pop ? "R4" : "R2", "direction", 32'(mem_we), 32'(!pop));
    check(pop ? "R4" : "R2", "address", 32'(mem_addr), 32'(exp_addr));
    check(pop ? "R4" : "R2", "offset", 32'(sp_o), 32'(exp_sp));
    check("R6", "busy", 32'(cmd_ready), 32'd0);
    if (!pop) check("R3", "write word", 32'(mem_wdata), 32'(exp_word));
    @(negedge clk);
    check("R7", "request single", 32'(mem_req), 32'd0);
    if (pop) begin
      check("R5", "pop valid", 32'(pop_valid), 32'd1);
      check("R5", "pop data", 32'(pop_data), 32'(exp_word));
      check("R6", "pop busy 2nd cycle", 32'(cmd_ready), 32'd0);
      @(negedge clk);
      check("R5", "pop valid pulse", 32'(pop_valid), 32'd0);
    end
    check("R6", "ready again", 32'(cmd_ready), 32'd1);
  endtask

  // pop, wide, data, addr, sp after, word (write data or popped data)
  localparam int NV = 8;
  localparam logic [57:0] VECS [NV] = '{
    {1'b0, 1'b0, 16'hABFF, 16'h0010, 8'h12, 16'h00FF},
    {1'b0, 1'b1, 16'h1234, 16'h0012, 8'h14, 16'h1234},
    {1'b0, 1'b0, 16'h5A77, 16'h0014, 8'h16, 16'h0077},
    {1'b1, 1'b0, 16'h0000, 16'h0014, 8'h14, 16'h0077},
    {1'b1, 1'b1, 16'hFFFF, 16'h0012, 8'h12, 16'h1234},
    {1'b0, 1'b1, 16'hBEEF, 16'h0012, 8'h14, 16'hBEEF},
    {1'b1, 1'b0, 16'h0000, 16'h0012, 8'h12, 16'hBEEF},
    {1'b1, 1'b0, 16'h0000, 16'h0010, 8'h10, 16'h00FF}
  };

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "segment", 32'(ss_o), 32'd2);
    check("R1", "offset", 32'(sp_o), 32'd0);
    check("R1", "ready", 32'(cmd_ready), 32'd1);
    check("R1", "no request", 32'(mem_req), 32'd0);
    check("R1", "no pop", 32'(pop_valid), 32'd0);
    run_cmd(1'b0, 1'b1, 16'hC0DE, 16'h0200, 8'h02, 16'hC0DE); // R1 start address

    load(8'h00, 8'h10);
    for (int i = 0; i < NV; i++) begin
      logic [57:0] v;
      v = VECS[i];
      run_cmd(v[57], v[56], v[55:40], v[39:24], v[23:16], v[15:0]);
    end

    // R8 wrap upward and downward
    load(8'h03, 8'hFE);
    run_cmd(1'b0, 1'b1, 16'h55AA, 16'h03FE, 8'h00, 16'h55AA);
    check("R8", "segment kept", 32'(ss_o), 32'h03);
    run_cmd(1'b1, 1'b1, 16'h0000, 16'h03FE, 8'hFE, 16'h55AA);
    load(8'h03, 8'h00);
    run_cmd(1'b1, 1'b0, 16'h0000, 16'h03FE, 8'hFE, 16'h55AA);

    // R9 load and push in the same cycle
    ld_en = 1'b1; ld_ss = 8'h05; ld_sp = 8'h40;
    run_cmd(1'b0, 1'b1, 16'h0BAD, 16'h0540, 8'h42, 16'h0BAD);
    check("R9", "segment from load", 32'(ss_o), 32'h05);

    // R10 odd offset still served
    load(8'h05, 8'h11);
    run_cmd(1'b0, 1'b0, 16'h1234, 16'h0511, 8'h13, 16'h0034);

    // R6 commands held while busy are ignored
    load(8'h01, 8'h20);
    cmd_valid = 1'b1; cmd_pop = 1'b0; cmd_wide = 1'b1; cmd_data = 16'h7777;
    @(negedge clk);
    cmd_pop = 1'b1;
    check("R2", "held push address", 32'(mem_addr), 32'h0120);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R6", "no request while busy", 32'(mem_req), 32'd0);
    check("R6", "offset moved once", 32'(sp_o), 32'h22);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_pop = 1'b1;
    @(negedge clk);
    cmd_pop = 1'b0; cmd_data = 16'h9999;
    check("R4", "held pop address", 32'(mem_addr), 32'h0120);
    @(negedge clk);
    check("R5", "held pop data", 32'(pop_data), 32'h7777);
    check("R6", "no request in response", 32'(mem_req), 32'd0);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R6", "no request after pop", 32'(mem_req), 32'd0);
    check("R6", "offset after pop", 32'(sp_o), 32'h20);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule